// File: doc/BRIEF.md
# QPSK Differential Decoder with Serial Output

This block sits after the symbol decision stage of a QPSK demodulator. A Costas-type carrier loop can settle at any of four lock points, 90 degrees apart, so the absolute phase of each recovered symbol cannot be trusted. The block takes the sign decisions of the I and Q arms on each symbol strobe and places the symbol in one of four quadrants. The transmitted dibit is carried by the change in quadrant from one symbol to the next, so the block recovers it from that change. A fixed rotation of the recovered carrier then adds the same offset to both quadrants and drops out.

Each recovered dibit is sent out as two serial bits, most significant bit first. Each bit is marked by a one-cycle valid pulse. With symbols arriving at half the serial rate, the output is a continuous bit stream at the line rate, for example 9.856 Mbit/s from 4.928 Msymbol/s.

Top module: `qpsk_diff_deser`

## Requirements
- R1: While `rst_n` is low, and after its release until a decoded symbol is available, `bit_valid` is 0.
- R2: The quadrant is Gray mapped from the sign inputs, where `i_neg`/`q_neg` = 1 means the arm is negative: (i_neg,q_neg) = (0,0) gives quadrant 0, (1,0) gives 1, (1,1) gives 2 and (0,1) gives 3.
- R3: The first symbol strobe after reset only stores its quadrant and produces no output bits.
- R4: For every later strobe, d = (current quadrant − previous quadrant) mod 4 selects the dibit {b1,b0}: d=0 gives 00, d=1 gives 01, d=2 gives 11 and d=3 gives 10.
- R5: `bit_out` carries b1 with `bit_valid` high in the cycle after the strobe, and b0 with `bit_valid` high in the cycle after that.
- R6: `bit_valid` is high only in the two cycles following a decoded strobe. Idle cycles without a strobe produce no valid bits.
- R7: Rotating every input quadrant by the same fixed amount (0 to 3 steps) leaves the output bit stream unchanged.
- R8: Strobes must be at least two cycles apart. At exactly two cycles apart, the output is an unbroken stream of valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | Symbol decision strobe |
| i_neg | input | 1 | I arm sign, 1 = negative |
| q_neg | input | 1 | Q arm sign, 1 = negative |
| bit_out | output | 1 | Serial decoded data bit |
| bit_valid | output | 1 | One-cycle qualifier for `bit_out` |

## Verification
The hardest case to reach from the ports is proving that the output does not depend on the carrier lock point. That needs the same symbol sequence presented under every possible quadrant rotation, with identical bit streams compared. The bench resets the block, plays a random sequence, then replays it after a reset at each of the other three rotations and compares the captured streams bit for bit. Dense back-to-back strobes are mixed with random idle gaps, so that the second bit of one dibit meets the strobe of the next symbol.

// File: rtl/qpsk_diff_deser.sv
module qpsk_diff_deser #(
  parameter int QW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sym_valid,
  input  logic i_neg,
  input  logic q_neg,
  output logic bit_out,
  output logic bit_valid
);

  logic [QW-1:0] quad, prev_q, diff;
  logic [1:0]    dibit;
  logic          have_prev, lsb_pend, lsb_hold;

  assign quad  = {q_neg, i_neg ^ q_neg};
  assign diff  = quad - prev_q;
  assign dibit = {diff[1], diff[1] ^ diff[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      have_prev <= 1'b0;
      lsb_pend  <= 1'b0;
      lsb_hold  <= 1'b0;
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (sym_valid) begin
        prev_q    <= quad;
        have_prev <= 1'b1;
        lsb_pend  <= have_prev;
        if (have_prev) begin
          bit_out   <= dibit[1];
          bit_valid <= 1'b1;
          lsb_hold  <= dibit[0];
        end
      end else if (lsb_pend) begin
        bit_out   <= lsb_hold;
        bit_valid <= 1'b1;
        lsb_pend  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qpsk_diff_deser_chk.sv
module qpsk_diff_deser_chk (
  input logic clk,
  input logic rst_n,
  input logic sym_valid,
  input logic i_neg,
  input logic q_neg,
  input logic bit_out,
  input logic bit_valid
);

  logic       seen;
  logic [1:0] cq, pq, d;
  logic       exp_msb, exp_lsb;

  always_comb begin
    case ({i_neg, q_neg})
      2'b00:   cq = 2'd0;
      2'b10:   cq = 2'd1;
      2'b11:   cq = 2'd2;
      default: cq = 2'd3;
    endcase
  end

  assign d       = cq - pq;
  assign exp_msb = (d == 2'd2) || (d == 2'd3);
  assign exp_lsb = (d == 2'd1) || (d == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      pq   <= 2'd0;
    end else if (sym_valid) begin
      seen <= 1'b1;
      pq   <= cq;
    end
  end

  p_first_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !seen |=> !bit_valid);

  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && seen |=> bit_valid && (bit_out == $past(exp_msb)));

  p_lsb_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && seen |=> ##1 (bit_valid && (bit_out == $past(exp_lsb, 2))));

  p_valid_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(sym_valid) || $past(sym_valid, 2));

endmodule

bind qpsk_diff_deser qpsk_diff_deser_chk i_chk (.*);

// File: tb/test_qpsk_diff_deser.sv
module test_qpsk_diff_deser;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic i_neg = 1'b0;
  logic q_neg = 1'b0;
  logic bit_out, bit_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] ref_prev;
  bit         ref_have;
  bit         cap [$];

  always #2.5 clk = ~clk;

  qpsk_diff_deser i_qpsk_diff_deser (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
    .i_neg(i_neg), .q_neg(q_neg),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );

  function automatic logic [1:0] quad_of(input logic in, input logic qn);
    if (!in && !qn) return 2'd0;
    if (in && !qn)  return 2'd1;
    if (in && qn)   return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [1:0] signs_of(input logic [1:0] q);
    case (q)
      2'd0: return 2'b00;
      2'd1: return 2'b10;
      2'd2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [1:0] dibit_of(input logic [1:0] d);
    case (d)
      2'd0: return 2'b00;
      2'd1: return 2'b01;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym_valid = 1'b0;
    #1;
    check("R1 in reset", {1'b0, bit_valid}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {1'b0, bit_valid}, 2'b00);
    ref_have = 1'b0;
    ref_prev = 2'd0;
    cap.delete();
  endtask

  task automatic send_q(input logic [1:0] q, input int idle, input string tag);
    logic [1:0] s, e;
    s = signs_of(q);
    i_neg = s[1];
    q_neg = s[0];
    sym_valid = 1'b1;
    e = dibit_of(q - ref_prev);
    @(negedge clk);
    sym_valid = 1'b0;
    if (!ref_have) begin
      check({tag, " R3 first silent"}, {1'b0, bit_valid}, 2'b00);
      @(negedge clk);
      check({tag, " R3 first silent"}, {1'b0, bit_valid}, 2'b00);
    end else begin
      check({tag, " R4 R5 msb"}, {bit_valid, bit_out}, {1'b1, e[1]});
      cap.push_back(bit_out);
      @(negedge clk);
      check({tag, " R4 R5 lsb"}, {bit_valid, bit_out}, {1'b1, e[0]});
      cap.push_back(bit_out);
    end
    ref_have = 1'b1;
    ref_prev = q;
    for (int k = 0; k < idle; k++) begin
      @(negedge clk);
      check({tag, " R6 idle"}, {1'b0, bit_valid}, 2'b00);
    end
  endtask

  initial begin
    logic [1:0] seq [32];
    bit         base [$];
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R2: each sign pair on its own, checked through the transition from quadrant 0
    for (int q = 0; q < 4; q++) begin
      do_reset();
      send_q(2'd0, 1, "R2 map");
      send_q(q[1:0], 1, "R2 map");
    end
    check("R2 helper", quad_of(1'b1, 1'b1), 2'd2);

    // R4: all 16 transitions, R8: strobes two cycles apart
    do_reset();
    send_q(2'd0, 0, "R8 dense");
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        send_q(a[1:0], 0, "R8 dense");
        send_q(b[1:0], 0, "R8 dense");
      end
    send_q(2'd1, 3, "R6 tail");

    // R7: same differences under all rotations
    for (int i = 0; i < 32; i++) seq[i] = 2'($urandom_range(0, 3));
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int i = 0; i < 32; i++)
        send_q(seq[i] + 2'(r), (i % 5 == 0) ? 2 : 0, "R7 rot");
      if (r == 0) base = cap;
      else begin
        check("R7 length", {1'b0, cap.size() == base.size()}, 2'b01);
        for (int i = 0; i < base.size() && i < cap.size(); i++)
          check("R7 stream", {1'b0, cap[i]}, {1'b0, base[i]});
      end
    end

    // random mix with gaps
    do_reset();
    for (int i = 0; i < 400; i++)
      send_q(2'($urandom_range(0, 3)), $urandom_range(0, 3), "R5 rand");

    // reset in the middle of a stream: next symbol is again the first
    send_q(2'd2, 0, "R3 pre");
    do_reset();
    send_q(2'd3, 1, "R3 after reset");
    send_q(2'd3, 1, "R4 zero diff");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule